// File: doc/BRIEF.md
# Loadable Burst Address Counter

This block generates the address for one port of a synchronous memory. Each cycle it decodes three active-low controls: counter clear, address load and count advance. From that decode it picks the address for the array. The choices are zero, the external address bus, the stored count plus one, or the stored count unchanged. On the rising clock edge the chosen address becomes the new stored count.

Clear has priority over load, and load has priority over advance. A burst therefore starts with one load cycle. After that the address steps by one each cycle while advance is held low. When the count passes the top of the address space it wraps back to zero.

Counting depends only on these three controls. The block has no chip-enable input and no byte-lane input, so deselecting the port does not stop the count. A clear drives address zero to the array in the same cycle, so no cycle is lost.

Top module: `burst_addr_gen`

## Requirements
- R1: While clr_n is low, addr_out is 0 in that cycle, whatever ld_n and adv_n are, and count_out is 0 after the next rising edge.
- R2: With clr_n high and ld_n low, addr_out equals ext_addr, and count_out holds that value after the rising edge, whatever adv_n is.
- R3: With clr_n and ld_n high and adv_n low, addr_out is count_out plus one, and count_out takes that value at the rising edge.
- R4: With clr_n, ld_n and adv_n all high, addr_out equals count_out, and count_out is unchanged across the edge.
- R5: Advancing from the all-ones address (2^ADDR_W - 1) gives address 0.
- R6: The value on addr_out in a cycle is the value count_out shows after that cycle's rising edge. This holds while rst_n is high.
- R7: A clear cycle followed directly by an advance cycle presents address 0 and then address 1, with no idle cycle between them.
- R8: A rising edge with rst_n low sets count_out to 0. This applies at power-on and in mid-run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous system reset, active low |
| clr_n | input | 1 | Counter clear, active low, highest priority |
| ld_n | input | 1 | Load external address, active low |
| adv_n | input | 1 | Advance counter by one, active low |
| ext_addr | input | ADDR_W | External address to load |
| addr_out | output | ADDR_W | Address presented to the array this cycle |
| count_out | output | ADDR_W | Stored counter value |

## Verification
The assertions assume that the controls and ext_addr are stable and known around each rising edge. They also assume rst_n is low at the first edge, so every past value they compare lies after reset. The bench changes every input only on the falling edge. It holds rst_n low for the first edges, and it makes only single-cycle reset pulses later in the run. The random stimulus gives clear a low weight. This lets long advance runs reach the wrap point, and a directed load of the all-ones address forces the wrap.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  // Operation chosen for a cycle, ordered by rising priority.
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_STEP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } addr_op_e;
endpackage

// File: rtl/bac_decode.sv
module bac_decode
  import burst_addr_pkg::*;
(
  input  logic     clr_n,
  input  logic     ld_n,
  input  logic     adv_n,
  output addr_op_e op
);
  // Fixed priority: clear, then load, then advance, else hold.
  always_comb begin
    if (!clr_n)      op = OP_CLEAR;
    else if (!ld_n)  op = OP_LOAD;
    else if (!adv_n) op = OP_STEP;
    else             op = OP_HOLD;
  end
endmodule

// File: rtl/bac_next.sv
module bac_next
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  addr_op_e            op,
  input  logic [ADDR_W-1:0]   cur,
  input  logic [ADDR_W-1:0]   ext,
  output logic [ADDR_W-1:0]   nxt
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  // Modulo-2^ADDR_W increment; the carry out of the top bit is dropped.
  function automatic logic [ADDR_W-1:0] step_wrap(input logic [ADDR_W-1:0] v);
    return v + ONE;
  endfunction

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = ext;
      OP_STEP:  nxt = step_wrap(cur);
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/bac_reg.sv
module bac_reg #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              ld_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] addr_out,
  output logic [ADDR_W-1:0] count_out
);
  addr_op_e          op_sel;
  logic [ADDR_W-1:0] sel_addr;
  logic [ADDR_W-1:0] cnt_q;

  bac_decode u_dec (
    .clr_n (clr_n),
    .ld_n  (ld_n),
    .adv_n (adv_n),
    .op    (op_sel)
  );

  bac_next #(.ADDR_W(ADDR_W)) u_nxt (
    .op  (op_sel),
    .cur (cnt_q),
    .ext (ext_addr),
    .nxt (sel_addr)
  );

  bac_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sel_addr),
    .q     (cnt_q)
  );

  assign addr_out  = sel_addr;
  assign count_out = cnt_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_n,
  input logic              ld_n,
  input logic              adv_n,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] addr_out,
  input logic [ADDR_W-1:0] count_out
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  wire do_clear = !clr_n;
  wire do_load  = clr_n && !ld_n;
  wire do_step  = clr_n && ld_n && !adv_n;
  wire do_hold  = clr_n && ld_n && adv_n;

  assert_clear_now_R1: assert property (@(posedge clk) disable iff (!rst_n)
    do_clear |-> addr_out == '0);
  assert_clear_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
    do_clear |=> count_out == '0);
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> count_out == $past(ext_addr));
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    do_step |=> count_out == $past(count_out) + ONE);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    do_hold |=> $stable(count_out));
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_step && (&count_out)) |=> count_out == '0);
  assert_present_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> count_out == $past(addr_out));
  assert_sysreset_R8: assert property (@(posedge clk)
    !rst_n |=> count_out == '0);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr_n     (clr_n),
  .ld_n      (ld_n),
  .adv_n     (adv_n),
  .ext_addr  (ext_addr),
  .addr_out  (addr_out),
  .count_out (count_out)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int W     = 12;
  localparam int DEPTH = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clr_n = 1'b1;
  logic         ld_n = 1'b1;
  logic         adv_n = 1'b1;
  logic [W-1:0] ext_addr = '0;
  logic [W-1:0] addr_out;
  logic [W-1:0] count_out;

  int n_cmp = 0;
  int n_bad = 0;
  logic [W-1:0] exp_cnt = '0;

  burst_addr_gen #(.ADDR_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ld_n(ld_n), .adv_n(adv_n),
    .ext_addr(ext_addr), .addr_out(addr_out), .count_out(count_out)
  );

  always #10 clk = ~clk;

  // Reference pick, written from the priority rules.
  function automatic logic [W-1:0] ref_pick(input logic c, input logic l,
      input logic a, input logic [W-1:0] cur, input logic [W-1:0] x);
    int v;
    v = int'(cur);
    if (c == 1'b0)      v = 0;
    else if (l == 1'b0) v = int'(x);
    else if (a == 1'b0) v = (v + 1) % DEPTH;
    return W'(v);
  endfunction

  function automatic string ref_tag(input logic c, input logic l, input logic a);
    if (!c) return "R1";
    if (!l) return "R2";
    if (!a) return "R3";
    return "R4";
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at the falling edge, check the presented address,
  // then check the stored count just after the rising edge.
  task automatic cycle(input logic r, input logic c, input logic l, input logic a,
                       input logic [W-1:0] x);
    logic [W-1:0] sel;
    @(negedge clk);
    rst_n = r; clr_n = c; ld_n = l; adv_n = a; ext_addr = x;
    #1;
    sel = ref_pick(c, l, a, exp_cnt, x);
    check({ref_tag(c, l, a), " present"}, addr_out, sel);
    @(posedge clk);
    exp_cnt = r ? sel : '0;
    #1;
    check(r ? "R6 stored" : "R8 reset", count_out, exp_cnt);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    check("R8 power-on", count_out, '0);
    exp_cnt = '0;

    // Load, advance, hold.
    cycle(1, 1, 0, 1, 12'h123);          // R2
    cycle(1, 1, 1, 0, 12'h000);          // R3 -> 124
    cycle(1, 1, 1, 0, 12'h000);          // R3 -> 125
    cycle(1, 1, 1, 1, 12'h7AB);          // R4 hold, ext ignored
    check("R4 hold value", count_out, 12'h125);
    // Load beats advance.
    cycle(1, 1, 0, 0, 12'h0F0);          // R2
    check("R2 load over advance", count_out, 12'h0F0);
    // Clear beats load and advance.
    cycle(1, 0, 0, 0, 12'h555);          // R1
    check("R1 clear priority", count_out, 12'h000);
    // R7: clear then advance, no dead cycle.
    cycle(1, 1, 0, 1, 12'h321);
    cycle(1, 0, 1, 1, 12'h000);
    @(negedge clk);
    clr_n = 1; ld_n = 1; adv_n = 0; #1;
    check("R7 step after clear", addr_out, 12'h001);
    @(posedge clk); exp_cnt = 12'h001;
    // R5: wrap from all ones.
    cycle(1, 1, 0, 1, 12'hFFF);
    cycle(1, 1, 1, 0, 12'h000);
    check("R5 wrap", count_out, 12'h000);
    cycle(1, 1, 1, 0, 12'h000);
    check("R5 after wrap", count_out, 12'h001);
    // R8 mid-run reset.
    cycle(1, 1, 0, 1, 12'hABC);
    cycle(0, 1, 1, 0, 12'h000);
    check("R8 mid-run", count_out, 12'h000);

    // Random mix with rare clears and loads near the top of the space.
    for (int i = 0; i < 3000; i++) begin
      logic c, l, a, r;
      logic [W-1:0] x;
      r = ($urandom % 200) != 0;
      c = ($urandom % 40) != 0;
      l = ($urandom % 12) != 0;
      a = ($urandom % 5) == 0;
      x = ($urandom % 2) ? W'(DEPTH - 1 - ($urandom % 8)) : W'($urandom);
      cycle(r, c, l, a, x);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule